// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive-side DMA engine of an Ethernet MAC. It walks a ring of two-word descriptors that software has placed in memory. Each descriptor has an address word, which holds the buffer pointer, an ownership flag and an end-of-ring marker. It also has a status word, which the engine fills in. When a frame arrives on the input stream, the engine reads the address word at its current ring position. If the engine owns that descriptor, it writes the frame beats into the buffer.

When the frame or the buffer ends, the engine writes the status word: length, start flag and end flag. It then rewrites the address word with the ownership flag set, which returns the descriptor to software. The pointer then moves to the next descriptor, or back to the ring base after a descriptor that carries the end-of-ring marker. A frame longer than one buffer continues in the following descriptors. A frame that meets a descriptor still held by software is discarded, and a one-cycle error pulse is raised.

Memory is reached through a simple request port. A request is held on mem_valid until mem_ready accepts it, and read data comes back on a separate mem_rvalid strobe. Frame beats enter on a valid/ready stream of 32-bit words with a last marker, and every beat counts as 4 bytes. s_ready is only raised while a beat can be written to memory in the same cycle, so a stalled memory stalls the stream. The source must hold s_valid, s_data and s_last until s_ready accepts the beat. A buffer size setting of zero is not supported.

Top module: `rxd_ring_writer`

## Requirements
- R1: During and right after reset, s_ready, mem_valid and rx_drop are all low.
- R2: When a frame starts with reception enabled, the engine reads the address word at the current ring position before it accepts the first beat.
- R3: If bit 0 of the fetched address word is 1, the whole frame is consumed and discarded: rx_drop pulses for one cycle, nothing is written to memory, and the next frame uses the same descriptor.
- R4: Beat k of a buffer is written to byte address (address word with bits 1:0 cleared) + 4k.
- R5: Status is written to descriptor address + 4 before the address word is rewritten, and status bits 31:16 are zero.
- R6: On write-back, the address word is rewritten with bit 0 set and bits 31:1 unchanged.
- R7: Status bits 13:0 hold the total frame length in bytes (4 per beat) in the buffer that ends the frame, and the buffer size in bytes in every other buffer.
- R8: The buffer size is buf_units × 64 bytes. A longer frame spans several descriptors. Status bit 14 is set only in the first buffer and bit 15 only in the last, and a frame that ends exactly when a buffer fills closes in that buffer.
- R9: After a descriptor whose address word has bit 1 set, the next fetch is at ring_base. Otherwise it is at the previous descriptor + 8.
- R10: While rx_en is low and no frame is in progress, no beat is accepted, no memory access is made, and the ring pointer returns to ring_base.
- R11: If a later descriptor of a spanning frame is owned by software, the remaining beats are discarded and rx_drop pulses. Buffers already written stay handed back, and the owned descriptor is not written.
- R12: Under memory back-pressure no beat is lost or duplicated, and an unaccepted descriptor request holds its address, data and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| ring_base | input | 32 | Byte address of descriptor 0 (8-byte aligned) |
| buf_units | input | UNIT_W | Buffer size in 64-byte units |
| s_valid | input | 1 | Frame beat valid |
| s_ready | output | 1 | Frame beat accepted |
| s_data | input | 32 | Frame beat data |
| s_last | input | 1 | Final beat of the frame |
| mem_valid | output | 1 | Memory request |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rx_drop | output | 1 | One-cycle pulse when a frame is discarded |

## Verification
The end of a frame and the filling of a buffer can land on the same beat. When they do, the engine must close the frame in that buffer with the end flag and the total length, and it must not fetch another descriptor. A sweep of frame lengths from 1 to 48 beats, with a 16-beat buffer, lands the last beat on every buffer position, including exact multiples. Each such coincidence is judged from the status words and from the count of descriptor fetches. The sweep also rolls the ring over its end-of-ring descriptor, both with memory always ready and with pseudo-random stalls.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_FILL,
    ST_WB_STAT,
    ST_WB_ADDR,
    ST_DROP
  } rxd_state_e;

  localparam int OWN_BIT  = 0;
  localparam int WRAP_BIT = 1;
endpackage

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
  parameter int AW   = 32,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic          load_base,
  input  logic          advance,
  input  logic          wrap,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load_base) begin
      ptr <= base;
    end else if (advance) begin
      ptr <= wrap ? base : ptr + AW'(STEP);
    end
  end
endmodule

// File: rtl/rxd_beat_count.sv
module rxd_beat_count #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer #(
  parameter int UNIT_W = 8,
  parameter int LEN_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [31:0]       ring_base,
  input  logic [UNIT_W-1:0] buf_units,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [31:0]       s_data,
  input  logic              s_last,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              rx_drop
);
  import rxd_pkg::*;

  localparam int BUFW_W = UNIT_W + 4;   // words per buffer: units * 16
  localparam int FRMW_W = LEN_W - 2;    // words per frame

  rxd_state_e        state_q;
  logic [29:0]       buf_addr_q;
  logic              wrap_q;
  logic              sof_q;
  logic              eof_q;
  logic [31:0]       ring_ptr;
  logic [BUFW_W-1:0] buf_cnt;
  logic [FRMW_W-1:0] frm_cnt;
  logic [BUFW_W-1:0] buf_words;
  logic              beat;
  logic              buf_full;
  logic              frame_start;
  logic [LEN_W-1:0]  len_bytes;

  assign buf_words   = {buf_units, 4'b0000};
  assign beat        = s_valid && s_ready;
  assign buf_full    = (buf_cnt == buf_words - BUFW_W'(1));
  assign frame_start = (state_q == ST_IDLE) && rx_en && s_valid;
  assign len_bytes   = eof_q ? LEN_W'({frm_cnt, 2'b00}) : LEN_W'({buf_units, 6'b000000});

  rxd_ring_ptr #(.AW(32), .STEP(8)) ptr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .base     (ring_base),
    .load_base((state_q == ST_IDLE) && !rx_en),
    .advance  ((state_q == ST_WB_ADDR) && mem_ready),
    .wrap     (wrap_q),
    .ptr      (ring_ptr)
  );

  rxd_beat_count #(.W(BUFW_W)) buf_cnt_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (state_q == ST_WAIT),
    .inc  (beat && (state_q == ST_FILL)),
    .cnt  (buf_cnt)
  );

  rxd_beat_count #(.W(FRMW_W)) frm_cnt_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (frame_start),
    .inc  (beat && (state_q == ST_FILL)),
    .cnt  (frm_cnt)
  );

  always_comb begin
    s_ready   = 1'b0;
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ring_ptr;
    mem_wdata = '0;
    rx_drop   = 1'b0;
    unique case (state_q)
      ST_FETCH: mem_valid = 1'b1;
      ST_WAIT:  rx_drop = mem_rvalid && mem_rdata[OWN_BIT];
      ST_FILL: begin
        s_ready   = mem_ready;
        mem_valid = s_valid;
        mem_we    = 1'b1;
        mem_addr  = {buf_addr_q, 2'b00} + (32'(buf_cnt) << 2);
        mem_wdata = s_data;
      end
      ST_WB_STAT: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ring_ptr + 32'd4;
        mem_wdata = 32'({eof_q, sof_q, len_bytes});
      end
      ST_WB_ADDR: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {buf_addr_q, wrap_q, 1'b1};
      end
      ST_DROP:  s_ready = 1'b1;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      buf_addr_q <= '0;
      wrap_q     <= 1'b0;
      sof_q      <= 1'b0;
      eof_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (frame_start) begin
          state_q <= ST_FETCH;
          sof_q   <= 1'b1;
        end
        ST_FETCH: if (mem_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid) begin
          if (mem_rdata[OWN_BIT]) begin
            state_q <= ST_DROP;
          end else begin
            state_q    <= ST_FILL;
            buf_addr_q <= mem_rdata[31:2];
            wrap_q     <= mem_rdata[WRAP_BIT];
          end
        end
        ST_FILL: if (beat) begin
          if (s_last) begin
            eof_q   <= 1'b1;
            state_q <= ST_WB_STAT;
          end else if (buf_full) begin
            eof_q   <= 1'b0;
            state_q <= ST_WB_STAT;
          end
        end
        ST_WB_STAT: if (mem_ready) state_q <= ST_WB_ADDR;
        ST_WB_ADDR: if (mem_ready) begin
          sof_q   <= 1'b0;
          state_q <= eof_q ? ST_IDLE : ST_FETCH;
        end
        ST_DROP: if (s_valid && s_last) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxd_ring_writer_chk.sv
module rxd_ring_writer_chk #(
  parameter int UNIT_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rx_en,
  input logic [31:0]         ring_base,
  input logic [UNIT_W-1:0]   buf_units,
  input logic                s_ready,
  input logic                mem_valid,
  input logic                mem_ready,
  input logic                mem_we,
  input logic [31:0]         mem_addr,
  input logic [31:0]         mem_wdata,
  input logic                rx_drop,
  input rxd_pkg::rxd_state_e state,
  input logic [31:0]         ptr,
  input logic [UNIT_W+3:0]   buf_cnt
);
  import rxd_pkg::*;

  assert_quiet_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && state == ST_IDLE) |-> (!s_ready && !mem_valid));

  assert_ptr_rebase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && state == ST_IDLE) |=> (ptr == $past(ring_base)));

  assert_wrap_to_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WB_ADDR && mem_ready && mem_wdata[WRAP_BIT]) |=> (ptr == $past(ring_base)));

  assert_step_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WB_ADDR && mem_ready && !mem_wdata[WRAP_BIT]) |=> (ptr == $past(ptr) + 32'd8));

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && state != ST_FILL) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));

  assert_buf_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL && buf_units != '0) |-> (buf_cnt < {buf_units, 4'b0000}));

  assert_drop_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DROP) |-> !mem_valid);

  assert_drop_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> !rx_drop);

  assert_handback_own_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WB_ADDR && mem_valid) |-> (mem_we && mem_wdata[OWN_BIT] && mem_addr == ptr));
endmodule

bind rxd_ring_writer rxd_ring_writer_chk #(.UNIT_W(UNIT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_en    (rx_en),
  .ring_base(ring_base),
  .buf_units(buf_units),
  .s_ready  (s_ready),
  .mem_valid(mem_valid),
  .mem_ready(mem_ready),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .rx_drop  (rx_drop),
  .state    (state_q),
  .ptr      (ring_ptr),
  .buf_cnt  (buf_cnt)
);

// File: tb/rxd_ring_writer_tb_top.sv
module rxd_ring_writer_tb_top;
  localparam int          NDESC = 4;
  localparam logic [31:0] BASE  = 32'h100;
  localparam logic [31:0] BUFB  = 32'h400;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, rx_en;
  logic [31:0] ring_base;
  logic [7:0]  buf_units;
  logic        s_valid, s_ready, s_last;
  logic [31:0] s_data;
  logic        mem_valid, mem_ready, mem_we, mem_rvalid, rx_drop;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  rxd_ring_writer dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base), .buf_units(buf_units),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rx_drop(rx_drop)
  );

  logic [31:0] mem [0:1023];
  int checks = 0, fails = 0, sw_idx = 0;
  int n_wr_ring = 0, n_wr_buf = 0, n_rd = 0, n_drop = 0, n_beat = 0, n_order = 0, n_early = 0;
  logic [31:0] rd_log [0:15];
  logic [31:0] last_wr = '0;
  logic        fetched = 1'b0;
  logic        rand_ready = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign mem_ready = rand_ready ? lfsr[0] : 1'b1;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[11:2]] <= mem_wdata;
        if (mem_addr >= BASE && mem_addr < BASE + 8 * NDESC) begin
          n_wr_ring <= n_wr_ring + 1;
          if (mem_addr[2] == 1'b0) begin
            if (last_wr != mem_addr + 32'd4) n_order <= n_order + 1;
            fetched <= 1'b0;
          end
        end else begin
          n_wr_buf <= n_wr_buf + 1;
        end
        last_wr <= mem_addr;
      end else begin
        mem_rvalid        <= 1'b1;
        mem_rdata         <= mem[mem_addr[11:2]];
        rd_log[n_rd & 15] <= mem_addr;
        n_rd              <= n_rd + 1;
        fetched           <= 1'b1;
      end
    end
    if (rx_drop) n_drop <= n_drop + 1;
    if (s_valid && s_ready) begin
      n_beat <= n_beat + 1;
      if (!fetched) n_early <= n_early + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] desc_a(input int i);
    return BASE + 32'(8 * i);
  endfunction

  function automatic logic [31:0] buf_a(input int i);
    return BUFB + 32'(256 * i);
  endfunction

  task automatic arm(input int i);
    mem[desc_a(i) >> 2]         = buf_a(i) | ((i == NDESC - 1) ? 32'h2 : 32'h0);
    mem[(desc_a(i) >> 2) + 1]   = 32'hF000_0000;
  endtask

  task automatic send(input int fid, input int len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = {fid[15:0], k[15:0]};
      s_last  = (k == len - 1);
      #4;
      while (!s_ready) begin
        @(negedge clk);
        #4;
      end
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic wait_ring(input int target);
    int t = 0;
    while (n_wr_ring < target && t < 500) begin
      @(posedge clk);
      t++;
    end
    repeat (3) @(posedge clk);
  endtask

  task automatic do_frame(input int fid, input int len);
    int nbuf, wr0, rd0, b0, e0, idx, wl, blen, bad;
    logic [31:0] st, aw, expv;
    bit sof, eof;
    nbuf = (len + 15) / 16;
    wr0 = n_wr_ring; rd0 = n_rd; b0 = n_beat; e0 = n_early;
    send(fid, len);
    wait_ring(wr0 + 2 * nbuf);
    @(negedge clk);
    chk(n_beat - b0 == len, "R12", "beats accepted", n_beat - b0, len);
    chk(n_early == e0, "R2", "beats before fetch", n_early - e0, 0);
    chk(n_order == 0, "R5", "status-before-address order errors", n_order, 0);
    chk(n_rd - rd0 == nbuf, "R8", "descriptors fetched", n_rd - rd0, nbuf);
    bad = 0;
    for (int j = 0; j < nbuf; j++) begin
      idx  = (sw_idx + j) % NDESC;
      sof  = (j == 0);
      eof  = (j == nbuf - 1);
      wl   = eof ? len - 16 * j : 16;
      blen = eof ? len * 4 : 64;
      st   = mem[(desc_a(idx) >> 2) + 1];
      aw   = mem[desc_a(idx) >> 2];
      chk(st[31:16] == 16'h0, "R5", "status upper bits", st[31:16], 0);
      chk(st[15:14] == {eof, sof}, "R8", "end/start flags", st[15:14], {eof, sof});
      chk(st[13:0] == blen[13:0], "R7", "length field", st[13:0], blen);
      expv = buf_a(idx) | ((idx == NDESC - 1) ? 32'h2 : 32'h0) | 32'h1;
      chk(aw == expv, "R6", "handed-back address word", aw, expv);
      chk(rd_log[(rd0 + j) & 15] == desc_a(idx), "R9", "fetch address",
          rd_log[(rd0 + j) & 15], desc_a(idx));
      for (int k = 0; k < wl; k++)
        if (mem[(buf_a(idx) >> 2) + k] != {fid[15:0], 16'(16 * j + k)}) bad++;
    end
    chk(bad == 0, "R4", "payload words wrong", bad, 0);
    for (int j = 0; j < nbuf; j++) arm((sw_idx + j) % NDESC);
    sw_idx = (sw_idx + nbuf) % NDESC;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R12 watchdog expired actual=%0d expected=<%0d cycles", 100000, 100000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int idx, nxt, d0, w0, r0, acc;
    logic [31:0] st;
    rst_n = 1'b0; rx_en = 1'b0; ring_base = BASE; buf_units = 8'd1;
    s_valid = 1'b0; s_data = '0; s_last = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int i = 0; i < NDESC; i++) arm(i);
    repeat (3) @(negedge clk);
    chk(!s_ready && !mem_valid && !rx_drop, "R1", "outputs in reset",
        {s_ready, mem_valid, rx_drop}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!s_ready && !mem_valid && !rx_drop, "R1", "outputs after reset",
        {s_ready, mem_valid, rx_drop}, 0);
    rx_en = 1'b1;

    // Sweep frame lengths across buffer boundaries and ring wrap (R7, R8, R9)
    for (int len = 1; len <= 48; len++) begin
      rand_ready = (len > 24);
      do_frame(len, len);
    end

    // Owned descriptor at frame start: whole frame dropped (R3)
    idx = sw_idx;
    mem[desc_a(idx) >> 2] = mem[desc_a(idx) >> 2] | 32'h1;
    d0 = n_drop; w0 = n_wr_ring + n_wr_buf;
    send(200, 5);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(n_drop - d0 == 1, "R3", "drop pulses", n_drop - d0, 1);
    chk(n_wr_ring + n_wr_buf == w0, "R3", "writes during drop", n_wr_ring + n_wr_buf - w0, 0);
    arm(idx);
    do_frame(201, 3);
    chk(rd_log[(n_rd - 1) & 15] == desc_a(idx), "R3", "same descriptor reused",
        rd_log[(n_rd - 1) & 15], desc_a(idx));

    // Owned descriptor in mid-frame (R11)
    idx = sw_idx; nxt = (idx + 1) % NDESC;
    mem[desc_a(nxt) >> 2] = mem[desc_a(nxt) >> 2] | 32'h1;
    d0 = n_drop; w0 = n_wr_ring;
    send(202, 20);
    wait_ring(w0 + 2);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(n_drop - d0 == 1, "R11", "mid-frame drop pulses", n_drop - d0, 1);
    st = mem[(desc_a(idx) >> 2) + 1];
    chk(st == 32'h0000_4040, "R11", "first buffer status", st, 32'h0000_4040);
    chk(mem[(desc_a(nxt) >> 2) + 1] == 32'hF000_0000, "R11", "owned descriptor untouched",
        mem[(desc_a(nxt) >> 2) + 1], 32'hF000_0000);
    chk(mem[(buf_a(idx) >> 2) + 15] == {16'd202, 16'd15}, "R11", "first buffer tail word",
        mem[(buf_a(idx) >> 2) + 15], {16'd202, 16'd15});
    chk(n_wr_ring - w0 == 2, "R11", "ring writes", n_wr_ring - w0, 2);
    arm(idx); arm(nxt);
    sw_idx = nxt;
    do_frame(203, 2);
    if (sw_idx == 0) do_frame(204, 1);

    // Disable: nothing accepted, pointer back to base (R10)
    @(negedge clk);
    rx_en = 1'b0;
    r0 = n_rd; acc = 0;
    s_valid = 1'b1; s_data = 32'hDEAD_BEEF; s_last = 1'b1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      #4;
      if (s_ready || mem_valid) acc++;
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
    chk(acc == 0, "R10", "activity while disabled", acc, 0);
    chk(n_rd == r0, "R10", "fetches while disabled", n_rd - r0, 0);
    rx_en = 1'b1;
    sw_idx = 0;
    r0 = n_rd;
    do_frame(205, 4);
    chk(rd_log[r0 & 15] == BASE, "R10", "first fetch after re-enable", rd_log[r0 & 15], BASE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule